// File: doc/BRIEF.md
# Gapless multichannel serial audio transmitter

This block turns parallel audio sample words into one continuous serial stream. It drives four lines: a bit clock derived from the system clock, a data line, a word marker and a frame marker. Every bit-clock period carries one new data bit, and words follow each other with no idle periods. The word marker is high during the first bit of every sample. The frame marker is high during the first bit of every channel-0 sample, so a receiver can find both word and frame alignment without counting clocks from power-up.

Samples enter through a valid/ready handshake. Each sample comes with a channel index. The block holds one sample ahead of the word it is sending. It accepts a sample only when that sample's channel is the next one due. If no sample is held when the next word must begin, the block sends a word of zeros and sets a sticky underrun flag. The channel count, word width and bit-clock divider are parameters.

Top module: `ast_serial_tx`

## Requirements
- R1: After reset, bclk, sd_out, word_sync, frame_sync and underrun are all low. The first sample the block will take is for channel 0.
- R2: bclk is high for exactly HALF system clocks and then low for exactly HALF system clocks, without end.
- R3: sd_out, word_sync and frame_sync change only on the system clock edge at which bclk falls. A receiver therefore samples them on the bclk rising edge.
- R4: Each word occupies exactly WORD_W bclk periods and is sent most significant bit first. The next word's first bit follows the previous word's last bit with no idle period.
- R5: word_sync is high during the first bit period of every word and low during all other bit periods.
- R6: frame_sync is high only during the first bit period of a channel-0 word, and is high during every such bit period.
- R7: Word slots cycle through channels 0, 1, …, NUM_CH−1 in ascending order and then repeat.
- R8: in_ready is low whenever in_chan differs from the channel of the next slot to be loaded. A sample for any other channel waits until that channel comes due.
- R9: The block holds one sample. A sample accepted for channel c is sent, unaltered, in the next word slot of channel c.
- R10: If a slot starts with no sample held, that word is all zeros and underrun goes high. underrun stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The offered sample is taken at this clock edge |
| in_chan | input | CHW | Channel index of the offered sample |
| in_word | input | WORD_W | Sample value |
| bclk | output | 1 | Generated bit clock |
| sd_out | output | 1 | Serial data, MSB first |
| word_sync | output | 1 | High during the first bit of each word |
| frame_sync | output | 1 | High during the first bit of each channel-0 word |
| underrun | output | 1 | Sticky flag: a slot was filled with zeros |

## Verification
The bench builds the block with three channels, 8-bit words and a divider of two. The odd channel count exercises the channel wrap at a point that is not a power of two, where a stereo build would not. The short words let many complete frames, a starved stretch and a refill fit into a short run. A receiver model recovers each word on bclk rising edges and checks it against a scoreboard of accepted samples tagged by channel. Wrong-channel offers are made while the holding slot is empty, so that a wrongful accept would show up at in_ready.

// File: rtl/ast_pkg.sv
package ast_pkg;

   // Width of an index that counts 0..n-1, never narrower than one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ast_bclk_gen.sv
module ast_bclk_gen #(
   parameter int unsigned HALF = 2
)(
   input  logic clk,
   input  logic rst_n,
   output logic bclk,
   output logic fall_tick
);

   generate
      if (HALF == 1) begin : g_direct
         // Bit clock toggles on every system clock.
         always_ff @(posedge clk) begin
            if (!rst_n) bclk <= 1'b0;
            else        bclk <= ~bclk;
         end
         assign fall_tick = bclk;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF);
         logic [CW-1:0] div_q;
         logic          wrap;

         assign wrap = (div_q == CW'(HALF - 1));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
               bclk  <= 1'b0;
            end else if (wrap) begin
               div_q <= '0;
               bclk  <= ~bclk;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end
         // True in the cycle whose closing edge drives bclk low.
         assign fall_tick = wrap & bclk;
      end
   endgenerate

endmodule

// File: rtl/ast_slot_seq.sv
module ast_slot_seq
   import ast_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CHW   = idx_bits(NUM_CH),
   localparam int unsigned BW    = idx_bits(WORD_W)
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fall_tick,
   output logic           boundary,
   output logic [CHW-1:0] cur_ch,
   output logic           word_sync,
   output logic           frame_sync
);

   logic [BW-1:0] bit_q;
   logic          last_bit;

   assign last_bit = (bit_q == BW'(WORD_W - 1));
   assign boundary = fall_tick & last_bit;

   // Starts on the last bit so that the first falling edge opens channel 0.
   always_ff @(posedge clk) begin
      if (!rst_n)         bit_q <= BW'(WORD_W - 1);
      else if (boundary)  bit_q <= '0;
      else if (fall_tick) bit_q <= bit_q + 1'b1;
   end

   generate
      if (NUM_CH == 1) begin : g_mono
         assign cur_ch = '0;
      end else begin : g_multi
         logic [CHW-1:0] ch_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               ch_q <= CHW'(NUM_CH - 1);
            else if (boundary)
               ch_q <= (ch_q == CHW'(NUM_CH - 1)) ? '0 : ch_q + 1'b1;
         end
         assign cur_ch = ch_q;
      end
   endgenerate

   assign word_sync  = (bit_q == '0);
   assign frame_sync = word_sync & (cur_ch == '0);

endmodule

// File: rtl/ast_feed.sv
module ast_feed
   import ast_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned CHW   = idx_bits(NUM_CH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary,
   input  logic              in_valid,
   input  logic [CHW-1:0]    in_chan,
   input  logic [WORD_W-1:0] in_word,
   output logic              in_ready,
   output logic [CHW-1:0]    want_ch,
   output logic [WORD_W-1:0] load_word,
   output logic              underrun
);

   logic              held_q;
   logic [WORD_W-1:0] hold_q;
   logic              take;

   // No accept on a load edge: the wanted channel moves on at that edge.
   assign in_ready = ~held_q & ~boundary & (in_chan == want_ch);
   assign take     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q   <= 1'b0;
         hold_q   <= '0;
         want_ch  <= '0;
         underrun <= 1'b0;
      end else if (boundary) begin
         held_q  <= 1'b0;
         want_ch <= (want_ch == CHW'(NUM_CH - 1)) ? '0 : want_ch + 1'b1;
         if (!held_q) underrun <= 1'b1;
      end else if (take) begin
         held_q <= 1'b1;
         hold_q <= in_word;
      end
   end

   assign load_word = held_q ? hold_q : '0;

endmodule

// File: rtl/ast_shift.sv
module ast_shift #(
   parameter int unsigned WORD_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_tick,
   input  logic              boundary,
   input  logic [WORD_W-1:0] load_word,
   output logic              sd_out
);

   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         sh_q <= '0;
      else if (boundary)  sh_q <= load_word;
      else if (fall_tick) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
   end

   assign sd_out = sh_q[WORD_W-1];

endmodule

// File: rtl/ast_serial_tx.sv
module ast_serial_tx
   import ast_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned HALF   = 2,
   localparam int unsigned CHW   = idx_bits(NUM_CH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CHW-1:0]    in_chan,
   input  logic [WORD_W-1:0] in_word,
   output logic              bclk,
   output logic              sd_out,
   output logic              word_sync,
   output logic              frame_sync,
   output logic              underrun
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("ast_serial_tx: WORD_W must be at least 2");
      end
      if (NUM_CH < 1) begin : g_bad_count
         $error("ast_serial_tx: NUM_CH must be at least 1");
      end
      if (HALF < 1) begin : g_bad_div
         $error("ast_serial_tx: HALF must be at least 1");
      end
   endgenerate

   logic              fall_tick;
   logic              boundary;
   logic [CHW-1:0]    cur_ch;
   logic [CHW-1:0]    want_ch;
   logic [WORD_W-1:0] load_word;

   ast_bclk_gen #(.HALF(HALF)) u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk      (bclk),
      .fall_tick (fall_tick)
   );

   ast_slot_seq #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_tick  (fall_tick),
      .boundary   (boundary),
      .cur_ch     (cur_ch),
      .word_sync  (word_sync),
      .frame_sync (frame_sync)
   );

   ast_feed #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_feed (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (boundary),
      .in_valid  (in_valid),
      .in_chan   (in_chan),
      .in_word   (in_word),
      .in_ready  (in_ready),
      .want_ch   (want_ch),
      .load_word (load_word),
      .underrun  (underrun)
   );

   ast_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_tick (fall_tick),
      .boundary  (boundary),
      .load_word (load_word),
      .sd_out    (sd_out)
   );

endmodule

// File: rtl/ast_serial_tx_checks.sv
module ast_serial_tx_checks
   import ast_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned HALF   = 2,
   localparam int unsigned CHW   = idx_bits(NUM_CH)
)(
   input logic           clk,
   input logic           rst_n,
   input logic           bclk,
   input logic           sd_out,
   input logic           word_sync,
   input logic           frame_sync,
   input logic           underrun,
   input logic [CHW-1:0] cur_ch,
   input logic [CHW-1:0] want_ch
);

   // R3: serial lines move only together with a falling bit clock.
   p_lines_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(bclk) |-> ($stable(sd_out) && $stable(word_sync) && $stable(frame_sync)));

   // R6: frame marker only ever sits inside a word marker.
   p_frame_in_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |-> word_sync);

   // R10: underrun is sticky.
   p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);

   // R7: feed side always wants the channel after the one being sent.
   p_feed_follows_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      want_ch == ((cur_ch == CHW'(NUM_CH - 1)) ? '0 : cur_ch + 1'b1));

   logic        bclk_q;
   int unsigned run_cnt;
   int unsigned fall_cnt;
   logic        seen_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_q    <= 1'b0;
         run_cnt   <= 0;
         fall_cnt  <= 0;
         seen_word <= 1'b0;
      end else begin
         bclk_q <= bclk;
         // R2: each bclk level lasts HALF system clocks.
         if (bclk != bclk_q) begin
            p_half_period_r2: assert (run_cnt == HALF);
            run_cnt <= 1;
         end else begin
            run_cnt <= run_cnt + 1;
         end
         // R4: word marker recurs every WORD_W falling edges.
         if (bclk_q && !bclk) begin
            if (word_sync) begin
               if (seen_word) begin
                  p_word_len_r4: assert (fall_cnt == WORD_W);
               end
               seen_word <= 1'b1;
               fall_cnt  <= 1;
            end else begin
               fall_cnt <= fall_cnt + 1;
            end
         end
      end
   end

endmodule

bind ast_serial_tx ast_serial_tx_checks #(
   .NUM_CH (NUM_CH),
   .WORD_W (WORD_W),
   .HALF   (HALF)
) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .bclk       (bclk),
   .sd_out     (sd_out),
   .word_sync  (word_sync),
   .frame_sync (frame_sync),
   .underrun   (underrun),
   .cur_ch     (cur_ch),
   .want_ch    (want_ch)
);

// File: tb/test_ast_serial_tx.sv
`timescale 1ns/1ps
module test_ast_serial_tx;

   localparam int unsigned NUM_CH = 3;
   localparam int unsigned WORD_W = 8;
   localparam int unsigned HALF   = 2;
   localparam int unsigned CHW    = ast_pkg::idx_bits(NUM_CH);
   localparam int unsigned SLOT   = WORD_W * 2 * HALF;

   typedef struct packed {
      logic [CHW-1:0]    ch;
      logic [WORD_W-1:0] d;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic              in_ready;
   logic [CHW-1:0]    in_chan;
   logic [WORD_W-1:0] in_word;
   logic              bclk, sd_out, word_sync, frame_sync, underrun;

   always #2.5 clk = ~clk;

   ast_serial_tx #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .HALF(HALF)) i_ast_serial_tx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_chan(in_chan), .in_word(in_word), .bclk(bclk), .sd_out(sd_out),
      .word_sync(word_sync), .frame_sync(frame_sync), .underrun(underrun)
   );

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 0;
   exp_t q[$];

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [WORD_W-1:0] pat(input int k);
      case (k)
         0: return WORD_W'(8'h80);
         1: return WORD_W'(8'h01);
         2: return WORD_W'(8'hFF);
         3: return WORD_W'(8'hA5);
         4: return WORD_W'(8'h5A);
         default: return WORD_W'(k * 37 + 13);
      endcase
   endfunction

   task automatic send(input int ch, input logic [WORD_W-1:0] d);
      in_valid = 1'b1;
      in_chan  = CHW'(ch);
      in_word  = d;
      #0.2;
      while (!in_ready) begin
         @(negedge clk);
         #0.2;
      end
      @(posedge clk);
      q.push_back('{ch: CHW'(ch), d: d});
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Offers a wrong channel while the holding slot is empty, then the right one.
   task automatic send_probe(input int ch, input logic [WORD_W-1:0] d);
      in_valid = 1'b1;
      in_chan  = CHW'((ch + 1) % NUM_CH);
      in_word  = ~d;
      while (word_sync) @(negedge clk);
      while (!word_sync) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         #0.2;
         check(!in_ready, "R8 wrong channel refused mid-stream", in_ready, 0);
         @(negedge clk);
      end
      send(ch, d);
   endtask

   // Receiver model and scoreboard monitor.
   logic              bclk_q;
   logic [2:0]        prev3;
   int                run, bits, mon_ch, zero_words;
   bit                seen_tog, in_wd;
   logic [WORD_W-1:0] acc;

   always @(negedge clk) begin
      if (!rst_n) begin
         bclk_q = 1'b0; prev3 = 3'b000; run = 0; bits = 0; mon_ch = 0;
         seen_tog = 0; in_wd = 0; acc = '0; zero_words = 0;
      end else begin
         run++;
         if (bclk != bclk_q) begin
            if (seen_tog) check(run == HALF, "R2 bclk level length", run, HALF);
            seen_tog = 1;
            run = 0;
         end
         if ({sd_out, word_sync, frame_sync} != prev3)
            check(bclk_q && !bclk, "R3 line change away from bclk fall", bclk, 0);
         prev3 = {sd_out, word_sync, frame_sync};
         if (!bclk_q && bclk) begin
            if (word_sync) begin
               if (in_wd) check(bits == WORD_W, "R4 R5 word_sync spacing", bits, WORD_W);
               check(frame_sync == (mon_ch == 0), "R6 frame_sync at word start",
                     frame_sync, mon_ch == 0);
               bits = 1;
               acc = {{(WORD_W-1){1'b0}}, sd_out};
               in_wd = 1;
            end else if (in_wd) begin
               check(!frame_sync, "R6 frame_sync inside word", frame_sync, 0);
               if (bits == WORD_W) check(0, "R5 word_sync missing", 0, 1);
               acc = {acc[WORD_W-2:0], sd_out};
               bits++;
            end
            if (in_wd && bits == WORD_W) begin
               if (q.size() > 0 && q[0].ch == CHW'(mon_ch)) begin
                  exp_t e;
                  e = q.pop_front();
                  check(acc == e.d, "R4 R7 R9 word content", acc, e.d);
               end else begin
                  check(acc == '0, "R10 zero-filled slot", acc, 0);
                  check(underrun, "R10 underrun after empty slot", underrun, 1);
                  zero_words++;
               end
               mon_ch = (mon_ch == NUM_CH - 1) ? 0 : mon_ch + 1;
            end
         end
         bclk_q = bclk;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_chan = '0; in_word = '0;
      repeat (4) @(negedge clk);
      check(!bclk,       "R1 bclk low in reset", bclk, 0);
      check(!sd_out,     "R1 sd_out low in reset", sd_out, 0);
      check(!word_sync,  "R1 word_sync low in reset", word_sync, 0);
      check(!frame_sync, "R1 frame_sync low in reset", frame_sync, 0);
      check(!underrun,   "R1 underrun low in reset", underrun, 0);
      rst_n = 1'b1;
      in_valid = 1'b1; in_chan = CHW'(1); #0.2;
      check(!in_ready, "R8 channel 1 refused first", in_ready, 0);
      in_chan = '0; #0.2;
      check(in_ready, "R1 channel 0 due first", in_ready, 1);
      in_valid = 1'b0;
      for (int f = 0; f < 4; f++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (f == 2 && c == 1) send_probe(c, pat(f * NUM_CH + c));
            else                  send(c, pat(f * NUM_CH + c));
         end
      end
      check(!underrun, "R10 no underrun while fed", underrun, 0);
      while (q.size() > 0) @(negedge clk);
      repeat (2 * NUM_CH * SLOT) @(negedge clk);
      check(underrun, "R10 underrun after starving", underrun, 1);
      for (int c = 0; c < NUM_CH; c++) send(c, pat(20 + c));
      while (q.size() > 0) @(negedge clk);
      repeat (2 * SLOT) @(negedge clk);
      check(underrun, "R10 underrun stays set", underrun, 1);
      check(zero_words >= NUM_CH, "R10 zero words observed", zero_words, NUM_CH);
      check(q.size() == 0, "R9 every accepted sample sent", q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule